// File: doc/BRIEF.md
# DRAM Parallel Test-Mode Logic

This block is the device-side control of a small synchronous DRAM model. It samples the active-low row strobe, column strobe and write enable on every clock, detects their edges, and classifies each row-strobe cycle as an access, a column-before-row refresh, a row-only refresh or a test-mode set. Only the order in which the strobes move decides which kind of cycle it is. The block keeps a one-bit test-mode flag and reports every cycle it decodes through an event pulse with a kind code.

In normal mode a write or read touches the single cell picked by the latched row and the full column address. In test mode the two lowest column bits are ignored. One write stores the same data word in all four cells of the group, and a read returns, on each data bit, a pass/fail result: 1 when the four cells agree on that bit, 0 when they differ. The cell array is a small register file that clears on reset.

Top module: `dram_tm_model`

## Requirements
- R1: After reset, test_mode, dout_vld and cyc_evt are 0 and dout is 0. All cells hold 0.
- R2: On the clock where the row strobe is first sampled low while the column strobe and write enable are already low, test_mode becomes 1. In the same cycle cyc_evt is 1 and cyc_kind is 4 (test set).
- R3: On the clock where the row strobe is first sampled low while the column strobe is low and write enable is high, test_mode becomes 0. In the same cycle cyc_evt is 1 and cyc_kind is 2 (column-before-row refresh).
- R4: If the row strobe falls with the column strobe high and then rises with no column strobe fall in between, then on the clock where the rise is sampled test_mode becomes 0, cyc_evt is 1 and cyc_kind is 3 (row-only refresh).
- R5: The first column strobe fall inside a row cycle that began with the column strobe high gives cyc_evt=1 and cyc_kind=1 (access). Later column strobe falls in the same row cycle (page mode) still perform accesses but give no event.
- R6: In normal mode, a column strobe fall with write enable low stores din in the cell at row = addr[ROW_W-1:0] (taken at the row strobe fall) and column = addr[COL_W-1:0]. A fall with write enable high loads that cell into dout and sets dout_vld on the same clock. dout_vld clears on the clock where the column strobe rise is sampled.
- R7: In test mode, a write stores din in all four cells whose column matches the column address apart from its two low bits. The two low column bits do not matter, and cells of other groups are left unchanged.
- R8: In test mode, a read sets each bit of dout to 1 when that bit is equal in all four cells of the group and to 0 otherwise. dout_vld behaves as in R6.
- R9: Access cycles and repeated test-set cycles leave test_mode at 1. test_mode changes only on a clock that carries cyc_evt.
- R10: If the column strobe stays low while the row strobe rises and falls again, the rise gives no event and the fall is decoded as a column-before-row refresh. dout and dout_vld keep the value of the earlier read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| din | input | DQ_W | Write data |
| dout | output | DQ_W | Read data or per-bit test result |
| dout_vld | output | 1 | dout holds a read result |
| test_mode | output | 1 | Compressed test mode is active |
| cyc_evt | output | 1 | One-clock pulse when a cycle kind is decoded |
| cyc_kind | output | 3 | Kind of the last decoded cycle: 1 access, 2 refresh, 3 row-only refresh, 4 test set |

## Verification
Two functions can act on the same clock: a refresh decode and a read result that is still being held. In a hidden refresh the column strobe stays low after a read while the row strobe goes up and comes down again, so the refresh is decoded while dout_vld is still high. The bench runs this sequence and checks that the refresh event is reported with kind 2 on the row strobe fall, that the rise produces no row-only event, and that dout and dout_vld keep the value of the read until the column strobe rises.

// File: rtl/dtm_pkg.sv
package dtm_pkg;

    typedef enum logic [2:0] {
        CYC_NONE   = 3'd0,
        CYC_ACCESS = 3'd1,
        CYC_CBR    = 3'd2,
        CYC_RONLY  = 3'd3,
        CYC_TSET   = 3'd4
    } cyc_kind_e;

endpackage

// File: rtl/dtm_strobe_decode.sv
module dtm_strobe_decode
    import dtm_pkg::*;
#(
    parameter int ROW_W  = 2,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              test_mode,
    output logic              evt,
    output cyc_kind_e         kind,
    output logic              acc_stb,
    output logic              acc_we,
    output logic [ROW_W-1:0]  row,
    output logic              cas_rise
);

    typedef struct packed {
        logic             ras;
        logic             cas;
        logic             open;
        logic             seen;
        logic             mode;
        logic             evt;
        cyc_kind_e        kind;
        logic [ROW_W-1:0] row;
    } dec_s;

    dec_s dec_q, dec_d;

    logic ras_fall, ras_rise, cas_fall;

    always_comb begin
        ras_fall = dec_q.ras && !ras_n;
        ras_rise = !dec_q.ras && ras_n;
        cas_fall = dec_q.cas && !cas_n;
        cas_rise = !dec_q.cas && cas_n;
        acc_stb  = cas_fall && dec_q.open && !ras_n;
        acc_we   = !we_n;

        dec_d     = dec_q;
        dec_d.ras = ras_n;
        dec_d.cas = cas_n;
        dec_d.evt = 1'b0;

        if (ras_fall) begin
            if (!cas_n) begin
                dec_d.open = 1'b0;
                dec_d.evt  = 1'b1;
                if (!we_n) begin
                    dec_d.mode = 1'b1;
                    dec_d.kind = CYC_TSET;
                end else begin
                    dec_d.mode = 1'b0;
                    dec_d.kind = CYC_CBR;
                end
            end else begin
                dec_d.open = 1'b1;
                dec_d.seen = 1'b0;
                dec_d.row  = addr[ROW_W-1:0];
            end
        end else if (ras_rise) begin
            if (dec_q.open && !dec_q.seen) begin
                dec_d.evt  = 1'b1;
                dec_d.kind = CYC_RONLY;
                dec_d.mode = 1'b0;
            end
            dec_d.open = 1'b0;
        end else if (acc_stb) begin
            if (!dec_q.seen) begin
                dec_d.evt  = 1'b1;
                dec_d.kind = CYC_ACCESS;
            end
            dec_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q      <= '0;
            dec_q.ras  <= 1'b1;
            dec_q.cas  <= 1'b1;
            dec_q.kind <= CYC_NONE;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign test_mode = dec_q.mode;
    assign evt       = dec_q.evt;
    assign kind      = dec_q.kind;
    assign row       = dec_q.row;

    AST_TSET_SETS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && kind == CYC_TSET) |-> test_mode); // R2
    AST_CBR_EXITS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && kind == CYC_CBR) |-> !test_mode); // R3
    AST_RONLY_EXITS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && kind == CYC_RONLY) |-> !test_mode); // R4
    AST_EVT_HAS_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> (kind != CYC_NONE)); // R5
    AST_MODE_ONLY_ON_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(test_mode) |-> evt); // R9

endmodule

// File: rtl/dtm_cell_array.sv
module dtm_cell_array #(
    parameter int ROW_W = 2,
    parameter int COL_W = 4,
    parameter int DQ_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic             rd_stb,
    input  logic             test_mode,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    input  logic [DQ_W-1:0]  din,
    input  logic             out_clr,
    output logic [DQ_W-1:0]  dout,
    output logic             dout_vld
);

    localparam int IDX_W  = ROW_W + COL_W;
    localparam int DEPTH  = 1 << IDX_W;
    localparam int GRP_N  = 4;
    localparam int GCNT_W = $clog2(GRP_N + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DQ_W-1:0] mem;
        logic [DQ_W-1:0]            dout;
        logic                       vld;
    } arr_s;

    arr_s arr_q, arr_d;

    logic [IDX_W-1:0]  one_idx;
    logic [IDX_W-1:0]  grp_idx;
    logic [GCNT_W-1:0] ones;

    always_comb begin
        arr_d   = arr_q;
        one_idx = {row, col};
        grp_idx = '0;
        ones    = '0;

        if (wr_stb) begin
            if (test_mode) begin
                for (int g = 0; g < GRP_N; g++) begin
                    grp_idx = {row, col[COL_W-1:2], 2'(g)};
                    arr_d.mem[grp_idx] = din;
                end
            end else begin
                arr_d.mem[one_idx] = din;
            end
        end

        if (rd_stb) begin
            arr_d.vld = 1'b1;
            if (test_mode) begin
                for (int b = 0; b < DQ_W; b++) begin
                    ones = '0;
                    for (int g = 0; g < GRP_N; g++) begin
                        grp_idx = {row, col[COL_W-1:2], 2'(g)};
                        ones = ones + GCNT_W'(arr_q.mem[grp_idx][b]);
                    end
                    arr_d.dout[b] = (ones == '0) || (ones == GCNT_W'(GRP_N));
                end
            end else begin
                arr_d.dout = arr_q.mem[one_idx];
            end
        end else if (out_clr) begin
            arr_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_q <= '0;
        end else begin
            arr_q <= arr_d;
        end
    end

    assign dout     = arr_q.dout;
    assign dout_vld = arr_q.vld;

    AST_READ_SETS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> dout_vld); // R6
    AST_CLR_DROPS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_clr && !rd_stb) |=> !dout_vld); // R6
    AST_DOUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(dout)); // R10

endmodule

// File: rtl/dram_tm_model.sv
module dram_tm_model
    import dtm_pkg::*;
#(
    parameter int ROW_W = 2,
    parameter int COL_W = 4,
    parameter int DQ_W  = 4,
    localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DQ_W-1:0]   din,
    output logic [DQ_W-1:0]   dout,
    output logic              dout_vld,
    output logic              test_mode,
    output logic              cyc_evt,
    output logic [2:0]        cyc_kind
);

    logic             acc_stb, acc_we, cas_rise;
    logic [ROW_W-1:0] row;
    cyc_kind_e        kind;

    dtm_strobe_decode #(.ROW_W(ROW_W), .ADDR_W(ADDR_W)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .addr     (addr),
        .test_mode(test_mode),
        .evt      (cyc_evt),
        .kind     (kind),
        .acc_stb  (acc_stb),
        .acc_we   (acc_we),
        .row      (row),
        .cas_rise (cas_rise)
    );

    dtm_cell_array #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W)) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (acc_stb && acc_we),
        .rd_stb   (acc_stb && !acc_we),
        .test_mode(test_mode),
        .row      (row),
        .col      (addr[COL_W-1:0]),
        .din      (din),
        .out_clr  (cas_rise),
        .dout     (dout),
        .dout_vld (dout_vld)
    );

    assign cyc_kind = kind;

endmodule

// File: tb/tb_dram_tm_model.sv
module tb_dram_tm_model;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [3:0] addr = '0, din = '0;
    logic [3:0] dout;
    logic       dout_vld, test_mode, cyc_evt;
    logic [2:0] cyc_kind;

    int errs = 0, total = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dram_tm_model dut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_vld(dout_vld),
        .test_mode(test_mode), .cyc_evt(cyc_evt), .cyc_kind(cyc_kind)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        check(act == exp, tag, act, exp);
    endtask

    // set strobes at a falling edge, return after the next falling edge
    task automatic step(input logic r, input logic c, input logic w,
                        input logic [3:0] a, input logic [3:0] d);
        ras_n = r; cas_n = c; we_n = w; addr = a; din = d;
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] r, input logic [3:0] c, input logic [3:0] d);
        step(1, 1, 1, 0, 0);
        step(0, 1, 1, r, 0);
        step(0, 0, 0, c, d);
        check(cyc_evt && cyc_kind == 3'd1, "R5 write access event", int'(cyc_kind), 1);
        step(0, 1, 1, c, 0);
        step(1, 1, 1, 0, 0);
    endtask

    task automatic rd(input logic [3:0] r, input logic [3:0] c, input int exp, input string tag);
        step(1, 1, 1, 0, 0);
        step(0, 1, 1, r, 0);
        step(0, 0, 1, c, 0);
        check(cyc_evt && cyc_kind == 3'd1, "R5 read access event", int'(cyc_kind), 1);
        check(dout_vld == 1'b1, "R6 dout_vld on read", int'(dout_vld), 1);
        chk_eq(tag, int'(dout), exp);
        step(0, 1, 1, c, 0);
        chk_eq("R6 dout_vld clears on column strobe rise", int'(dout_vld), 0);
        step(1, 1, 1, 0, 0);
    endtask

    task automatic tset();
        step(1, 1, 1, 0, 0);
        step(1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        check(cyc_evt && cyc_kind == 3'd4, "R2 test set event", int'(cyc_kind), 4);
        chk_eq("R2 test_mode set", int'(test_mode), 1);
        step(0, 1, 1, 0, 0);
        step(1, 1, 1, 0, 0);
    endtask

    task automatic cbr();
        step(1, 1, 1, 0, 0);
        step(1, 0, 1, 0, 0);
        step(0, 0, 1, 0, 0);
        check(cyc_evt && cyc_kind == 3'd2, "R3 refresh event", int'(cyc_kind), 2);
        chk_eq("R3 test_mode cleared", int'(test_mode), 0);
        step(0, 1, 1, 0, 0);
        step(1, 1, 1, 0, 0);
    endtask

    task automatic ronly(input logic [3:0] r);
        step(1, 1, 1, 0, 0);
        step(0, 1, 1, r, 0);
        chk_eq("R4 no event at row fall", int'(cyc_evt), 0);
        step(0, 1, 1, r, 0);
        step(1, 1, 1, 0, 0);
        check(cyc_evt && cyc_kind == 3'd3, "R4 row-only event", int'(cyc_kind), 3);
        chk_eq("R4 test_mode cleared", int'(test_mode), 0);
    endtask

    task automatic t_reset();
        chk_eq("R1 test_mode reset", int'(test_mode), 0);
        chk_eq("R1 dout_vld reset", int'(dout_vld), 0);
        chk_eq("R1 cyc_evt reset", int'(cyc_evt), 0);
        chk_eq("R1 dout reset", int'(dout), 0);
        rd(0, 0, 0, "R1 cell cleared");
    endtask

    task automatic t_normal();
        wr(1, 3, 4'h5);
        wr(2, 3, 4'hC);
        wr(1, 4, 4'h9);
        rd(1, 3, 5, "R6 read row1 col3");
        rd(2, 3, 12, "R6 read row2 col3");
        rd(1, 4, 9, "R6 read row1 col4");
        rd(1, 2, 0, "R6 neighbour untouched");
        // page mode: two column strobes in one row cycle
        step(1, 1, 1, 0, 0);
        step(0, 1, 1, 1, 0);
        step(0, 0, 1, 3, 0);
        check(cyc_evt && cyc_kind == 3'd1, "R5 first page access event", int'(cyc_kind), 1);
        step(0, 1, 1, 3, 0);
        step(0, 0, 1, 4, 0);
        chk_eq("R5 no event on second page access", int'(cyc_evt), 0);
        chk_eq("R5 second page access data", int'(dout), 9);
        step(0, 1, 1, 4, 0);
        step(1, 1, 1, 0, 0);
    endtask

    task automatic t_testmode();
        tset();
        wr(2, 5, 4'hA);
        chk_eq("R9 mode kept after write", int'(test_mode), 1);
        rd(2, 6, 15, "R8 equal group passes");
        chk_eq("R9 mode kept after read", int'(test_mode), 1);
        tset();
        chk_eq("R9 mode kept after repeated set", int'(test_mode), 1);
        cbr();
        rd(2, 4, 10, "R7 fill col4");
        rd(2, 7, 10, "R7 fill col7");
        rd(2, 3, 12, "R7 other group untouched");
        rd(2, 8, 0, "R7 next group untouched");
        wr(2, 5, 4'h3);
        tset();
        rd(2, 4, 6, "R8 mixed group per-bit compare");
        ronly(1);
        rd(2, 5, 3, "R4 normal read after exit");
    endtask

    task automatic t_hidden();
        wr(3, 1, 4'h7);
        step(1, 1, 1, 0, 0);
        step(0, 1, 1, 3, 0);
        step(0, 0, 1, 1, 0);
        chk_eq("R10 read before hidden refresh", int'(dout), 7);
        step(1, 0, 1, 0, 0);
        chk_eq("R10 no event on row rise", int'(cyc_evt), 0);
        step(0, 0, 1, 0, 0);
        check(cyc_evt && cyc_kind == 3'd2, "R10 hidden refresh event", int'(cyc_kind), 2);
        chk_eq("R10 dout held", int'(dout), 7);
        chk_eq("R10 dout_vld held", int'(dout_vld), 1);
        step(0, 1, 1, 0, 0);
        chk_eq("R10 dout_vld clears on column rise", int'(dout_vld), 0);
        step(1, 1, 1, 0, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_testmode();
        t_hidden();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errs++;
            total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errs, total);
            $finish;
        end
    end

endmodule